// File: doc/BRIEF.md
# External Interrupt Line Conditioner

This block sits between four external interrupt request pins and a larger interrupt controller. Each pin is brought into the clock domain through a two-flop synchronizer. Then, according to a per-line two-bit sense mode, it is treated either as a level (active high or active low) or as an edge (rising or falling). An edge sets a sticky per-line latch. A level is passed on as it stands. Each line yields one qualified request. The request is gated by that line's enable and by a master enable shared by all lines.

A single 32-bit control word configures the block. It is written and read back over a plain register port. The word holds the per-line enables, the sense modes, the master enable and a routing bit for the critical request class. It also holds four write-one-to-clear bits that acknowledge latched edges. These clear bits take effect only in the cycle of the write and always read back as zero.

Top module: `ext_irq_conditioner`

## Requirements
- R1: After reset the control word reads 0x00000000, every request output is low and the critical routing output is low.
- R2: A write stores the whole word. A read returns the last written value, except that bits 27:24 always read 0.
- R3: The critical routing output equals bit 0 of the control word (1 = route normally, 0 = hold back).
- R4: Line n's mode sits in bits (23-2n):(22-2n). Code 0 makes the request follow the synchronized pin (active high). Code 3 makes it follow the inverted synchronized pin (active low).
- R5: Code 1 (rising edge) sets the line's latch on a rising synchronized pin. The request then stays high after the pin falls. Falling edges set nothing.
- R6: Code 2 (falling edge) sets the latch on a falling synchronized pin. Rising edges set nothing.
- R7: Writing 1 to bit 27-n clears line n's latch. Writing 0 there leaves the latch as it is, and the bit of another line does not touch it.
- R8: Bit 11-n enables line n. While it is 0 the line's request is low, but the line's latch is kept, so the request returns once the line is enabled again.
- R9: Bit 12 is the master enable. While it is 0 no request is high. Setting it again restores the requests that are pending.
- R10: In a level mode the clear bit has no effect on the request.
- R11: When a clear write and a new edge on the same line fall in the same clock, the edge wins and the latch stays set.
- R12: A pin change shows up on a level-mode request two clocks later, and on an edge-mode request three clocks later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Write strobe for the control word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Control word read-back |
| ext_pin | input | 4 | Asynchronous external request pins |
| irq_req | output | 4 | Qualified request per line |
| crit_route | output | 1 | Critical-class routing select |

## Verification
The two functions that can meet in one clock are a software clear of a line's latch and a fresh edge on that same line. The bench provokes this by raising the pin and then timing a clear write so that it is sampled on the same edge at which the synchronized edge is detected. It then checks that the request stays high, and that a later clear without an edge does drop it. The timing of the collision is derived from the documented latency of two synchronizer stages plus the latch stage.

// File: rtl/eic_pkg.sv
package eic_pkg;

    localparam int NUM_LINES  = 4;
    localparam int CTRL_W     = 32;
    localparam int MASTER_BIT = 12;
    localparam int CRIT_BIT   = 0;
    localparam int EN_TOP     = 11;
    localparam int CLR_TOP    = 27;
    localparam int MODE_TOP   = 23;
    localparam int MODE_W     = 2;

    typedef enum logic [MODE_W-1:0] {
        SENSE_LVL_HI = 2'd0,
        SENSE_RISE   = 2'd1,
        SENSE_FALL   = 2'd2,
        SENSE_LVL_LO = 2'd3
    } sense_e;

    function automatic int en_bit(input int n);
        return EN_TOP - n;
    endfunction

    function automatic int clr_bit(input int n);
        return CLR_TOP - n;
    endfunction

    function automatic int mode_lo(input int n);
        return MODE_TOP - 1 - MODE_W * n;
    endfunction

    function automatic logic [CTRL_W-1:0] clr_mask();
        logic [CTRL_W-1:0] m;
        m = '0;
        for (int n = 0; n < NUM_LINES; n++) begin
            m[clr_bit(n)] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/eic_ctrl_reg.sv
module eic_ctrl_reg
    import eic_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr,
    input  logic [CTRL_W-1:0]    wdata,
    output logic [CTRL_W-1:0]    ctrl,
    output logic [NUM_LINES-1:0] clr_pulse
);

    localparam logic [CTRL_W-1:0] CLR_MASK = clr_mask();

    typedef struct packed {
        logic [CTRL_W-1:0] word;
    } reg_state_t;

    reg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr) begin
            st_d.word = wdata & ~CLR_MASK;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar n = 0; n < NUM_LINES; n++) begin : g_clr
        assign clr_pulse[n] = wr & wdata[clr_bit(n)];
    end

    assign ctrl = st_q.word;

endmodule

// File: rtl/eic_line.sv
module eic_line
    import eic_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pin,
    input  logic [MODE_W-1:0] mode,
    input  logic              clr,
    input  logic              enable,
    input  logic              master,
    output logic              req
);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   prev;
        logic                   latch;
    } line_state_t;

    line_state_t st_d, st_q;
    sense_e      sense;
    logic        s_now;
    logic        is_edge;
    logic        edge_hit;
    logic        level_hit;

    always_comb begin
        sense     = sense_e'(mode);
        s_now     = st_q.sync[SYNC_STAGES-1];
        is_edge   = (sense == SENSE_RISE) || (sense == SENSE_FALL);
        edge_hit  = (sense == SENSE_RISE) ? (s_now & ~st_q.prev)
                                          : (~s_now & st_q.prev);
        level_hit = (sense == SENSE_LVL_HI) ? s_now : ~s_now;

        st_d      = st_q;
        st_d.sync = {st_q.sync[SYNC_STAGES-2:0], pin};
        st_d.prev = s_now;
        if (is_edge) begin
            if (clr) begin
                st_d.latch = 1'b0;
            end
            if (edge_hit) begin
                st_d.latch = 1'b1;
            end
        end else begin
            st_d.latch = 1'b0;
        end

        req = enable & master & (is_edge ? st_q.latch : level_hit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/ext_irq_conditioner.sv
module ext_irq_conditioner
    import eic_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr,
    input  logic [CTRL_W-1:0]    reg_wdata,
    output logic [CTRL_W-1:0]    reg_rdata,
    input  logic [NUM_LINES-1:0] ext_pin,
    output logic [NUM_LINES-1:0] irq_req,
    output logic                 crit_route
);

    logic [CTRL_W-1:0]    ctrl;
    logic [NUM_LINES-1:0] clr_pulse;

    eic_ctrl_reg u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (reg_wr),
        .wdata     (reg_wdata),
        .ctrl      (ctrl),
        .clr_pulse (clr_pulse)
    );

    for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
        eic_line #(.SYNC_STAGES(SYNC_STAGES)) u_line (
            .clk    (clk),
            .rst_n  (rst_n),
            .pin    (ext_pin[n]),
            .mode   (ctrl[mode_lo(n) +: MODE_W]),
            .clr    (clr_pulse[n]),
            .enable (ctrl[en_bit(n)]),
            .master (ctrl[MASTER_BIT]),
            .req    (irq_req[n])
        );
    end

    assign reg_rdata  = ctrl;
    assign crit_route = ctrl[CRIT_BIT];

endmodule

// File: rtl/eic_checker.sv
module eic_checker
    import eic_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 reg_wr,
    input logic [CTRL_W-1:0]    reg_wdata,
    input logic [CTRL_W-1:0]    reg_rdata,
    input logic [NUM_LINES-1:0] ext_pin,
    input logic [NUM_LINES-1:0] irq_req,
    input logic                 crit_route
);

    logic [1:0] since_rst;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_rst <= '0;
        end else if (since_rst != 2'd3) begin
            since_rst <= since_rst + 2'd1;
        end
    end

    p_clr_reads_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[CLR_TOP -: NUM_LINES] == '0);

    p_write_stores_r2: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> reg_rdata == ($past(reg_wdata) & ~clr_mask()));

    p_crit_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> crit_route == $past(reg_wdata[CRIT_BIT]));

    p_master_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rdata[MASTER_BIT] |-> irq_req == '0);

    p_level_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd3 && reg_rdata[MASTER_BIT] && reg_rdata[en_bit(0)]
         && reg_rdata[mode_lo(0) +: MODE_W] == SENSE_LVL_HI)
        |-> irq_req[0] == $past(ext_pin[0], 2));

    for (genvar n = 0; n < NUM_LINES; n++) begin : g_line_chk
        p_enable_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
            !reg_rdata[en_bit(n)] |-> !irq_req[n]);

        p_edge_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (irq_req[n] && !reg_wr
             && (reg_rdata[mode_lo(n) +: MODE_W] == SENSE_RISE
                 || reg_rdata[mode_lo(n) +: MODE_W] == SENSE_FALL))
            |=> irq_req[n]);
    end

endmodule

bind ext_irq_conditioner eic_checker u_chk (.*);

// File: tb/tb_ext_irq_conditioner.sv
`timescale 1ns/1ps
module tb_ext_irq_conditioner;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [3:0]  ext_pin = '0;
    logic [3:0]  irq_req;
    logic        crit_route;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    ext_irq_conditioner dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .ext_pin    (ext_pin),
        .irq_req    (irq_req),
        .crit_route (crit_route)
    );

    // Control word built from the requirement bit positions:
    // master bit 12, enable n at 11-n, clear n at 27-n, mode n at (23-2n):(22-2n), crit bit 0
    function automatic logic [31:0] mk(input logic m, input logic [3:0] en,
                                       input logic [7:0] modes, input logic [3:0] clr,
                                       input logic crit);
        logic [31:0] w;
        w = '0;
        w[12] = m;
        w[0]  = crit;
        for (int n = 0; n < 4; n++) begin
            w[11-n] = en[n];
            w[27-n] = clr[n];
            w[22-2*n +: 2] = modes[2*n +: 2];
        end
        return w;
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [31:0] v);
        @(negedge clk);
        reg_wr = 1'b1;
        reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
        reg_wdata = '0;
    endtask

    task automatic t_reset;
        chk("R1 rdata", reg_rdata, 32'h0);
        chk("R1 irq", {28'h0, irq_req}, 32'h0);
        chk("R1 crit", {31'h0, crit_route}, 32'h0);
    endtask

    task automatic t_readback;
        wr(32'hFFFF_FFFF);
        chk("R2 clear bits read 0", reg_rdata, 32'hF0FF_FFFF);
        chk("R3 crit high", {31'h0, crit_route}, 32'h1);
        wr(32'h0000_5A3C);
        chk("R2 pattern", reg_rdata, 32'h0000_5A3C);
        chk("R3 crit low", {31'h0, crit_route}, 32'h0);
        wr(32'h0);
    endtask

    task automatic t_level;
        // line0 mode 0, line3 mode 3, lines 1/2 mode 0
        wr(mk(1'b1, 4'b1001, 8'b11_00_00_00, 4'h0, 1'b0));
        tick(1);
        chk("R4 idle levels", {28'h0, irq_req}, 32'h8);
        ext_pin = 4'b1001;
        tick(1);
        chk("R12 level not yet", {28'h0, irq_req}, 32'h8);
        tick(1);
        chk("R4 level after two", {28'h0, irq_req}, 32'h1);
        ext_pin = 4'b0000;
        tick(2);
        chk("R4 level drop", {28'h0, irq_req}, 32'h8);
        wr(32'h0);
    endtask

    task automatic t_rise;
        logic [31:0] cfg;
        cfg = mk(1'b1, 4'b0010, 8'b00_00_01_00, 4'h0, 1'b0);
        wr(cfg);
        ext_pin[1] = 1'b1;
        tick(2);
        chk("R12 edge not yet", {31'h0, irq_req[1]}, 32'h0);
        tick(1);
        chk("R5 rise latched", {31'h0, irq_req[1]}, 32'h1);
        ext_pin[1] = 1'b0;
        tick(4);
        chk("R5 sticky after fall", {31'h0, irq_req[1]}, 32'h1);
        wr(cfg | (32'h1 << 26));
        chk("R7 clear line1", {31'h0, irq_req[1]}, 32'h0);
        ext_pin[1] = 1'b1;
        tick(3);
        wr(cfg | (32'h1 << 26));
        ext_pin[1] = 1'b0;
        tick(4);
        chk("R5 falling ignored", {31'h0, irq_req[1]}, 32'h0);
        wr(32'h0);
    endtask

    task automatic t_fall;
        logic [31:0] cfg;
        cfg = mk(1'b1, 4'b0100, 8'b00_10_00_00, 4'h0, 1'b0);
        wr(cfg);
        ext_pin[2] = 1'b1;
        tick(4);
        chk("R6 rising ignored", {31'h0, irq_req[2]}, 32'h0);
        ext_pin[2] = 1'b0;
        tick(3);
        chk("R6 fall latched", {31'h0, irq_req[2]}, 32'h1);
        wr(cfg);
        chk("R7 zero no effect", {31'h0, irq_req[2]}, 32'h1);
        wr(cfg | (32'h1 << 26));
        chk("R7 other line clear", {31'h0, irq_req[2]}, 32'h1);
        wr(cfg & ~(32'h1 << 9));
        chk("R8 disabled low", {31'h0, irq_req[2]}, 32'h0);
        wr(cfg);
        chk("R8 re-enabled kept", {31'h0, irq_req[2]}, 32'h1);
        wr(cfg & ~(32'h1 << 12));
        chk("R9 master off", {28'h0, irq_req}, 32'h0);
        wr(cfg);
        chk("R9 master on", {31'h0, irq_req[2]}, 32'h1);
        wr(cfg | (32'h1 << 25));
        chk("R7 clear line2", {31'h0, irq_req[2]}, 32'h0);
        wr(32'h0);
    endtask

    task automatic t_level_clear;
        logic [31:0] cfg;
        cfg = mk(1'b1, 4'b0001, 8'b00_00_00_00, 4'h0, 1'b0);
        wr(cfg);
        ext_pin[0] = 1'b1;
        tick(2);
        chk("R4 line0 high", {31'h0, irq_req[0]}, 32'h1);
        wr(cfg | (32'h1 << 27));
        chk("R10 clear ignored", {31'h0, irq_req[0]}, 32'h1);
        ext_pin[0] = 1'b0;
        wr(32'h0);
    endtask

    task automatic t_collide;
        logic [31:0] cfg;
        cfg = mk(1'b1, 4'b0010, 8'b00_00_01_00, 4'h0, 1'b0);
        wr(cfg);
        tick(2);
        ext_pin[1] = 1'b1;
        tick(2);
        reg_wr = 1'b1;
        reg_wdata = cfg | (32'h1 << 26);
        @(negedge clk);
        reg_wr = 1'b0;
        reg_wdata = '0;
        chk("R11 edge beats clear", {31'h0, irq_req[1]}, 32'h1);
        wr(cfg | (32'h1 << 26));
        chk("R11 later clear", {31'h0, irq_req[1]}, 32'h0);
        ext_pin[1] = 1'b0;
        wr(32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        tick(1);
        t_reset();
        t_readback();
        t_level();
        t_rise();
        t_fall();
        t_level_clear();
        t_collide();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule